// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Pulse Outputs

This block is a 16-bit up-counter whose behaviour is chosen by an 8-bit control register. One byte-wide register pair holds a value that is either loaded into the counter or filled from it. Its three uses are:

- **Capture:** a falling edge on a trigger pin copies the running count into the register pair.
- **Auto-reload:** the counter restarts from the register pair on overflow, or on a trigger-pin falling edge.
- **Baud generation:** overflow pulses go out to clock a serial receiver and/or transmitter. In this use the overflow flag stays clear, and the counter always reloads.

The counter advances on one of two sources. It can take an internal tick strobe, which gives at most one step per system clock. It can instead take falling edges on an external count pin. Both external pins pass through a synchronizer before their falling edges are detected.

Software reaches the block through a small register bus. Writes are strobed. Reads are combinational from the address. An interrupt request is raised while either status flag is set.

Top module: `cap_reload_timer`

## Requirements
- R1: After a synchronous active-low reset the following all read 0: the control register, the count and the register pair. `irq` and both baud pulse outputs are 0.
- R2: Control register bits, from bit 7 down to bit 0: overflow flag, trigger flag, receive-baud select, transmit-baud select, trigger enable, run, external-count select, capture select.
- R3: A count event advances the count by one. A count event happens only while run is 1. With external-count select at 1, it is a synchronized falling edge of `cnt_pin`, and `tick_en` is ignored. With external-count select at 0, it is `tick_en`.
- R4: When a count event finds the count at 0xFFFF, that is an overflow. In reload use (capture select 0, or either baud select 1) the count takes the register pair value. In capture use it wraps to 0.
- R5: An overflow sets the overflow flag unless either baud select is 1. The flag stays set until a control write changes it.
- R6: With trigger enable 1, capture select 1 and both baud selects 0, a trigger-pin falling edge copies the count into the register pair and sets the trigger flag.
- R7: With trigger enable 1, capture select 0 and both baud selects 0, a trigger-pin falling edge loads the register pair into the count and sets the trigger flag.
- R8: With trigger enable 0, or with either baud select 1, trigger-pin edges change neither the count, the register pair nor the trigger flag.
- R9: With a baud select at 1, each overflow produces a one-cycle pulse on the matching output (`rx_baud_pulse` for receive, `tx_baud_pulse` for transmit). The pulse appears in the cycle after the overflow. Capture select is ignored, and the counter reloads.
- R10: `irq` is the OR of the two flags. A control write loads both flags with the written bits, so software can set or clear them. A hardware set in the same cycle as the write wins.
- R11: A pin falling edge takes effect at the third rising clock edge after the pin changes.
- R12: Register addresses: 0 is control, 1 is count low byte, 2 is count high byte, 3 is register pair low byte, 4 is register pair high byte. Any other address reads 0. A software write to a count byte takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tick_en | input | 1 | Internal count strobe |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | Capture/reload trigger pin (asynchronous) |
| irq | output | 1 | Interrupt request |
| rx_baud_pulse | output | 1 | Overflow pulse for receive clocking |
| tx_baud_pulse | output | 1 | Overflow pulse for transmit clocking |

## Verification
The bench builds the block with its defaults: an 8-bit data width, which gives a 16-bit count, and two synchronizer stages. With a 16-bit count, a count preset just below 0xFFFF reaches overflow, reload and wrap within a few ticks. Two stages fix the pin-to-effect latency at three edges, so the trigger and count-pin checks can be sampled at fixed cycles.

// File: rtl/crt_pkg.sv
// Shared types for the capture/reload timer.
// Assumes an 8-bit control register whose bit order software decodes.
package crt_pkg;
    localparam int unsigned ADDR_W = 3;

    // Control register, bit 7 first.
    typedef struct packed {
        logic ovf;      // overflow flag
        logic ext;      // trigger flag
        logic rx_sel;   // receive baud select
        logic tx_sel;   // transmit baud select
        logic ext_en;   // trigger enable
        logic run;      // run
        logic cnt_sel;  // external count select
        logic cap_sel;  // capture select
    } crt_ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CAP_LO = 3'd3,
        A_CAP_HI = 3'd4
    } crt_addr_e;
endpackage

// File: rtl/crt_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops.
// Flags a falling edge for one cycle by comparing the last two synchronized samples.
// Assumes the pin idles high. STAGES must be at least 2.
module crt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A high-to-low change between the two newest samples is a falling edge.
    assign fall_o = prev_q & ~sync_q[STAGES-1];

    // A falling edge can never be flagged on two cycles in a row.
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/crt_ctrl_reg.sv
// Control register with two sticky status flags.
// A bus write loads all bits. A hardware set of a flag is ORed in afterwards, so it wins over a clear in the same cycle.
module crt_ctrl_reg
    import crt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_i,
    input  crt_ctrl_t wdata_i,
    input  logic      ovf_set_i,
    input  logic      ext_set_i,
    output crt_ctrl_t ctrl_o
);
    crt_ctrl_t ctrl_q, ctrl_d;

    // Next value: the bus write first, then the hardware flag sets.
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) ctrl_d = wdata_i;
        ctrl_d.ovf = ctrl_d.ovf | ovf_set_i;
        ctrl_d.ext = ctrl_d.ext | ext_set_i;
    end

    // Register the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ovf && !wr_i) |=> ctrl_q.ovf);
    a_r10_ovf_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set_i |=> ctrl_q.ovf);
    a_r10_ext_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set_i |=> ctrl_q.ext);
endmodule

// File: rtl/crt_counter.sv
// Up-counter and capture/reload register pair, each 2*DATA_W bits wide.
// Count priority: bus byte write, then reload or wrap on overflow, then trigger reload, then increment.
// For the register pair, a hardware capture wins over a bus write.
module crt_counter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_evt_i,
    input  logic                reload_mode_i,
    input  logic                trig_reload_i,
    input  logic                trig_capture_i,
    input  logic                wr_cnt_lo_i,
    input  logic                wr_cnt_hi_i,
    input  logic                wr_cap_lo_i,
    input  logic                wr_cap_hi_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [2*DATA_W-1:0] count_o,
    output logic [2*DATA_W-1:0] cap_o,
    output logic                ovf_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] cap_q, cap_d;

    // An overflow is a count event that finds the count at all ones.
    assign ovf_o = cnt_evt_i & (&count_q);

    // Next count value.
    always_comb begin
        count_d = count_q;
        if (ovf_o)               count_d = reload_mode_i ? cap_q : '0;
        else if (trig_reload_i)  count_d = cap_q;
        else if (cnt_evt_i)      count_d = count_q + 1'b1;
        if (wr_cnt_lo_i) count_d[DATA_W-1:0]     = wdata_i;
        if (wr_cnt_hi_i) count_d[CNT_W-1:DATA_W] = wdata_i;
    end

    // Next register pair value.
    always_comb begin
        cap_d = cap_q;
        if (wr_cap_lo_i) cap_d[DATA_W-1:0]     = wdata_i;
        if (wr_cap_hi_i) cap_d[CNT_W-1:DATA_W] = wdata_i;
        if (trig_capture_i) cap_d = count_q;
    end

    // Register the count and the register pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            cap_q   <= '0;
        end else begin
            count_q <= count_d;
            cap_q   <= cap_d;
        end
    end

    assign count_o = count_q;
    assign cap_o   = cap_q;

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && reload_mode_i && !wr_cnt_lo_i && !wr_cnt_hi_i)
        |=> count_q == $past(cap_q));
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !reload_mode_i && !wr_cnt_lo_i && !wr_cnt_hi_i)
        |=> count_q == '0);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        trig_capture_i |=> cap_q == $past(count_q));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_evt_i && !trig_reload_i && !wr_cnt_lo_i && !wr_cnt_hi_i)
        |=> count_q == $past(count_q));
endmodule

// File: rtl/cap_reload_timer.sv
// Top of the capture/reload timer.
// Ties together the pin synchronizers, the control register and the counter.
// Decodes bus writes, registers the baud pulses and muxes the read data.
// Assumes the external pins idle high and that DATA_W is the control register width.
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              irq,
    output logic              rx_baud_pulse,
    output logic              tx_baud_pulse
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    crt_ctrl_t        ctrl;
    logic             cnt_fall, trig_fall;
    logic             baud, cnt_evt, trig_evt, ovf;
    logic             wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;
    logic [CNT_W-1:0] count, cap;

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin), .fall_o(cnt_fall));
    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(trig_pin), .fall_o(trig_fall));

    // Bus write decode.
    always_comb begin
        wr_ctrl   = wr_en && (addr == A_CTRL);
        wr_cnt_lo = wr_en && (addr == A_CNT_LO);
        wr_cnt_hi = wr_en && (addr == A_CNT_HI);
        wr_cap_lo = wr_en && (addr == A_CAP_LO);
        wr_cap_hi = wr_en && (addr == A_CAP_HI);
    end

    // Event qualification from the control bits.
    always_comb begin
        baud     = ctrl.rx_sel | ctrl.tx_sel;
        cnt_evt  = ctrl.run & (ctrl.cnt_sel ? cnt_fall : tick_en);
        trig_evt = ctrl.ext_en & ~baud & trig_fall;
    end

    crt_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
        .wdata_i(crt_ctrl_t'(wdata)),
        .ovf_set_i(ovf & ~baud), .ext_set_i(trig_evt),
        .ctrl_o(ctrl));

    crt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .cnt_evt_i(cnt_evt),
        .reload_mode_i(baud | ~ctrl.cap_sel),
        .trig_reload_i(trig_evt & ~ctrl.cap_sel),
        .trig_capture_i(trig_evt & ctrl.cap_sel),
        .wr_cnt_lo_i(wr_cnt_lo), .wr_cnt_hi_i(wr_cnt_hi),
        .wr_cap_lo_i(wr_cap_lo), .wr_cap_hi_i(wr_cap_hi),
        .wdata_i(wdata),
        .count_o(count), .cap_o(cap), .ovf_o(ovf));

    // Baud pulses, one cycle after each overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_baud_pulse <= 1'b0;
            tx_baud_pulse <= 1'b0;
        end else begin
            rx_baud_pulse <= ovf & ctrl.rx_sel;
            tx_baud_pulse <= ovf & ctrl.tx_sel;
        end
    end

    // Read data mux.
    always_comb begin
        case (addr)
            A_CTRL:   rdata = ctrl;
            A_CNT_LO: rdata = count[DATA_W-1:0];
            A_CNT_HI: rdata = count[CNT_W-1:DATA_W];
            A_CAP_LO: rdata = cap[DATA_W-1:0];
            A_CAP_HI: rdata = cap[CNT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end

    assign irq = ctrl.ovf | ctrl.ext;

    a_r9_rx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rx_baud_pulse |-> $past(ctrl.rx_sel));
    a_r9_tx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        tx_baud_pulse |-> $past(ctrl.tx_sel));
    a_r5_baud_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ctrl.ovf && !wr_ctrl) |=> !ctrl.ovf);
    a_r8_no_trig_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.ext_en && !ctrl.ext && !wr_ctrl) |=> !ctrl.ext);
endmodule

// File: tb/cap_reload_timer_tb_top.sv
`timescale 1ns/1ps
module cap_reload_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick_en = 1'b0;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       irq, rx_baud_pulse, tx_baud_pulse;

    int errors = 0;
    int checks = 0;
    int rx_seen = 0;
    int tx_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cap_reload_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_en(tick_en), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .irq(irq), .rx_baud_pulse(rx_baud_pulse), .tx_baud_pulse(tx_baud_pulse));

    // Count baud pulses, sampled away from the rising edge.
    always @(negedge clk) begin
        rx_seen += int'(rx_baud_pulse);
        tx_seen += int'(tx_baud_pulse);
    end

    // Fields, MSB first: ctrl, start count, register pair value, ticks, expected count, expected ctrl, overflows.
    localparam logic [79:0] VEC [7] = '{
        {8'h04, 16'hFFFE, 16'hFFF0, 8'd3,  16'hFFF1, 8'h84, 8'd1},
        {8'h05, 16'hFFFF, 16'h1234, 8'd2,  16'h0001, 8'h85, 8'd1},
        {8'h24, 16'hFFFF, 16'hFF00, 8'd2,  16'hFF01, 8'h24, 8'd1},
        {8'h35, 16'hFFFF, 16'hAB00, 8'd1,  16'hAB00, 8'h35, 8'd1},
        {8'h00, 16'h1000, 16'h0000, 8'd5,  16'h1000, 8'h00, 8'd0},
        {8'h04, 16'h0100, 16'h0000, 8'd10, 16'h010A, 8'h04, 8'd0},
        {8'h14, 16'hFFFD, 16'h8000, 8'd4,  16'h8001, 8'h14, 8'd1}
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic rd16(input logic [2:0] lo, output int v);
        int l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = (h << 8) | l;
    endtask

    task automatic set16(input logic [2:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 3'd1, v[15:8]);
    endtask

    task automatic trig_fall();
        @(negedge clk); trig_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_rise();
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, v);      chk("R1 ctrl", v, 0);
        rd16(1, v);    chk("R1 count", v, 0);
        rd16(3, v);    chk("R1 pair", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 pulses", int'(rx_baud_pulse | tx_baud_pulse), 0);

        // Vector walk: R2 R3 R4 R5 R9
        for (int i = 0; i < 7; i++) begin
            logic [7:0]  c, nt, ec, no;
            logic [15:0] st, rl, en;
            {c, st, rl, nt, en, ec, no} = VEC[i];
            wr(0, 8'h00);
            set16(1, st);
            set16(3, rl);
            wr(0, c);
            rx_seen = 0; tx_seen = 0;
            for (int t = 0; t < int'(nt); t++) begin
                tick_en = 1'b1;
                @(negedge clk);
            end
            tick_en = 1'b0;
            @(negedge clk);
            rd16(1, v);  chk("R3/R4 count", v, int'(en));
            rd(0, v);    chk("R2/R5 ctrl", v, int'(ec));
            rd16(3, v);  chk("R4 pair kept", v, int'(rl));
            chk("R10 irq", int'(irq), int'(ec[7] | ec[6]));
            chk("R9 rx pulses", rx_seen, c[5] ? int'(no) : 0);
            chk("R9 tx pulses", tx_seen, c[4] ? int'(no) : 0);
        end

        // R6, R11: capture on trigger fall
        wr(0, 8'h00); set16(1, 16'h4321); set16(3, 16'h0000);
        wr(0, 8'h0D);
        trig_fall();
        rd16(3, v); chk("R6 capture", v, 16'h4321);
        rd(0, v);   chk("R6 flag", v, 8'h4D);
        chk("R10 irq ext", int'(irq), 1);
        rd16(1, v); chk("R6 count kept", v, 16'h4321);
        trig_rise();

        // R10: software clear
        wr(0, 8'h0D);
        rd(0, v); chk("R10 sw clear", v, 8'h0D);
        chk("R10 irq clear", int'(irq), 0);

        // R8: trigger enable off
        wr(0, 8'h05); set16(1, 16'h1111);
        trig_fall();
        rd16(3, v); chk("R8 pair kept", v, 16'h4321);
        rd(0, v);   chk("R8 no flag", v, 8'h05);
        trig_rise();

        // R7: reload on trigger fall
        wr(0, 8'h00); set16(3, 16'h5555); set16(1, 16'h0010);
        wr(0, 8'h0C);
        trig_fall();
        rd16(1, v); chk("R7 reload", v, 16'h5555);
        rd(0, v);   chk("R7 flag", v, 8'h4C);
        trig_rise();

        // R8: baud mode ignores trigger
        wr(0, 8'h2C); set16(1, 16'h0020);
        trig_fall();
        rd16(1, v); chk("R8 baud count", v, 16'h0020);
        rd(0, v);   chk("R8 baud flag", v, 8'h2C);
        rd16(3, v); chk("R8 baud pair", v, 16'h5555);
        trig_rise();

        // R3, R11: external count pin, tick ignored
        wr(0, 8'h00); set16(1, 16'h0000);
        wr(0, 8'h06);
        tick_en = 1'b1;
        for (int p = 0; p < 3; p++) begin
            cnt_pin = 1'b0; repeat (2) @(negedge clk);
            cnt_pin = 1'b1; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        rd16(1, v); chk("R3 pin count", v, 3);

        // R10: hardware set wins over software clear
        wr(0, 8'h00); set16(1, 16'hFFFF);
        wr(0, 8'h04);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h04;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd(0, v);   chk("R10 hw wins", v, 8'h84);
        rd16(1, v); chk("R4 reload", v, 16'h5555);

        // R10: software set of a flag
        wr(0, 8'h40);
        chk("R10 sw set irq", int'(irq), 1);
        wr(0, 8'h00);

        // R12: unmapped address and count write priority
        rd(5, v); chk("R12 unmapped", v, 0);
        set16(1, 16'h00FE);
        wr(0, 8'h04);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h77;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd16(1, v); chk("R12 write wins", v, 16'h0077);

        summary();
    end
endmodule